// File: doc/BRIEF.md
# Voice Envelope Generator with Equality-Matched Rate Counter

This block produces the 8-bit amplitude envelope for one synthesizer voice. It advances once per cycle clock. Software programs it through a small byte-wide write port with three registers. One register holds the attack and decay rates. One holds the sustain level and the release rate. The third is a control register whose bit 0 is the gate. Setting the gate starts an attack. Clearing it starts a release.

A free-running rate counter sets the pace. Each phase picks one 4-bit rate code, and the code selects a period limit. When the counter equals that limit, the block issues one step and the counter restarts at zero. The match is on equality only, and two hardware quirks are kept on purpose. If the limit drops below the current count, the counter has to run all the way to its top value and wrap before it can match again. If an attack starts while the envelope is already at full level, the next step wraps the envelope to zero instead of holding it at full level.

Top module: `envgen_top`

## Requirements
- R1: While reset is asserted and after it is released, the envelope output is 0x00, the rate counter is 0, the phase is release, and all three registers hold zero.
- R2: Write addresses select the registers. Address 0 holds the attack rate in bits 7:4 and the decay rate in bits 3:0. Address 1 holds the sustain level in bits 7:4 and the release rate in bits 3:0. Address 2 holds the gate in bit 0. A write to address 3 changes nothing.
- R3: The 15-bit rate counter issues a step only in a cycle where it equals the limit of the current phase. In that same cycle it returns to 0, so one step period is limit+1 cycles.
- R4: Rate codes 0 to 15 map to the limits 9, 31, 62, 94, 149, 219, 266, 312, 391, 976, 1953, 3125, 3906, 11719, 19531 and 31250.
- R5: If the limit falls below the current count, the counter keeps counting up to 0x7FFF, wraps to 0, and only then matches. From a step at rate 4, a switch to rate 0 made 50 cycles later yields a 32778-cycle gap.
- R6: A register write takes effect in the middle of a period. A new, smaller limit that is still above the count matches in the same pass.
- R7: A write that changes the gate from 0 to 1 enters attack. A write that changes it from 1 to 0 enters release. Writing the gate value it already holds changes neither the phase nor the envelope.
- R8: In attack, each step adds one to the envelope. The step that brings it to 0xFF also moves the phase to decay.
- R9: An attack entered while the envelope is 0xFF wraps the envelope to 0x00 on its first step. It stays in attack and counts up from there.
- R10: In decay, each step subtracts one until the envelope equals the sustain nibble copied into both nibbles, and then it holds. An envelope below that level keeps falling and holds at 0x00.
- R11: In release, each step subtracts one, and the envelope holds at 0x00 without wrapping.
- R12: The envelope changes only on a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrAddr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| envOut | output | 8 | Envelope level |

## Verification
The bench builds the block with its default parameters: a 15-bit rate counter and 8-bit registers and envelope. With these values a full counter wrap takes 32768 cycles, so the bench can measure the real escape gap exactly within its cycle budget rather than a shortened copy of it. Short rate codes keep the full rise to 0xFF, the decay to sustain and the wrap at the top to a few thousand cycles each. Between the steps, the bench measures exact gaps for rates 0, 1 and 4, for the change of limit within a period, and for the escape.

// File: rtl/envgen_pkg.sv
package envgen_pkg;

  // Width of the limit constants below; the rate counter must be at least this wide.
  localparam int LIM_W = 15;

  localparam logic [1:0] ADDR_ATKDEC = 2'd0;
  localparam logic [1:0] ADDR_SUSREL = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_RELEASE = 2'd2
  } phase_e;

  // Strobes from control to the envelope datapath.
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } env_strobe_t;

  // Period limit for a 4-bit rate code (R4).
  function automatic logic [LIM_W-1:0] rateLimit(input logic [3:0] code);
    logic [LIM_W-1:0] lim;
    case (code)
      4'd0:  lim = 15'd9;
      4'd1:  lim = 15'd31;
      4'd2:  lim = 15'd62;
      4'd3:  lim = 15'd94;
      4'd4:  lim = 15'd149;
      4'd5:  lim = 15'd219;
      4'd6:  lim = 15'd266;
      4'd7:  lim = 15'd312;
      4'd8:  lim = 15'd391;
      4'd9:  lim = 15'd976;
      4'd10: lim = 15'd1953;
      4'd11: lim = 15'd3125;
      4'd12: lim = 15'd3906;
      4'd13: lim = 15'd11719;
      4'd14: lim = 15'd19531;
      default: lim = 15'd31250;
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/envgen_regs.sv
module envgen_regs
  import envgen_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] atkDecReg,
  output logic [DATA_W-1:0] susRelReg,
  output logic              gateSet,
  output logic              gateClr
);

  localparam int NUM_BYTE_REGS = 2;

  logic [DATA_W-1:0] byteRegs [NUM_BYTE_REGS];
  logic              gateReg;
  logic              ctrlWrite;

  // Byte registers at addresses 0 and 1 (R2).
  for (genvar i = 0; i < NUM_BYTE_REGS; i++) begin : g_byteReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        byteRegs[i] <= '0;
      end else if (wrEn && wrAddr == ADDR_W'(i)) begin
        byteRegs[i] <= wrData;
      end
    end
  end

  assign atkDecReg = byteRegs[ADDR_ATKDEC];
  assign susRelReg = byteRegs[ADDR_SUSREL];

  assign ctrlWrite = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));
  assign gateSet   = ctrlWrite &&  wrData[0] && !gateReg;
  assign gateClr   = ctrlWrite && !wrData[0] &&  gateReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateReg <= 1'b0;
    end else if (ctrlWrite) begin
      gateReg <= wrData[0];
    end
  end

  // R7: a gate edge is either a set or a clear, never both
  a_r7_gate_edges_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(gateSet && gateClr));

  // R7: a set pulse leaves the gate held high
  a_r7_gate_set_holds: assert property (@(posedge clk) disable iff (!rstN)
    gateSet |=> gateReg);

endmodule

// File: rtl/envgen_ctrl.sv
module envgen_ctrl
  import envgen_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] atkDecReg,
  input  logic [DATA_W-1:0] susRelReg,
  input  logic              gateSet,
  input  logic              gateClr,
  input  logic [DATA_W-1:0] envIn,
  output env_strobe_t       stb
);

  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ENV_PRE_TOP = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0]  CNT_MAX     = '1;

  phase_e            phase, phaseNext;
  logic [CNT_W-1:0]  rateCnt, rateCntNext, curLimit;
  logic [NIB_W-1:0]  rateCode;
  logic [DATA_W-1:0] susLevel;
  logic              rateHit;

  // Rate code of the current phase (R2).
  always_comb begin
    case (phase)
      PH_ATTACK: rateCode = atkDecReg[DATA_W-1 -: NIB_W];
      PH_DECAY:  rateCode = atkDecReg[NIB_W-1:0];
      default:   rateCode = susRelReg[NIB_W-1:0];
    endcase
  end

  assign curLimit    = CNT_W'(rateLimit(rateCode));
  assign rateHit     = (rateCnt == curLimit);
  assign rateCntNext = rateHit ? '0 : rateCnt + CNT_W'(1);
  assign susLevel    = {2{susRelReg[DATA_W-1 -: NIB_W]}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rateCnt <= '0;
    else       rateCnt <= rateCntNext;
  end

  // Step strobes toward the datapath.
  always_comb begin
    stb.stepUp   = rateHit && (phase == PH_ATTACK);
    stb.stepDown = 1'b0;
    if (rateHit && envIn != '0) begin
      if (phase == PH_RELEASE)                       stb.stepDown = 1'b1;
      else if (phase == PH_DECAY && envIn != susLevel) stb.stepDown = 1'b1;
    end
  end

  // Gate edges win over the attack-to-decay hand-off.
  always_comb begin
    phaseNext = phase;
    if (gateSet)                                  phaseNext = PH_ATTACK;
    else if (gateClr)                             phaseNext = PH_RELEASE;
    else if (stb.stepUp && envIn == ENV_PRE_TOP)  phaseNext = PH_DECAY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_RELEASE;
    else       phase <= phaseNext;
  end

  // R3: a match leaves the counter at zero for the next cycle
  a_r3_cnt_clears: assert property (@(posedge clk) disable iff (!rstN)
    rateHit |=> rateCnt == '0);

  // R5: without a match the counter only advances by one (escape path)
  a_r5_escape_counts: assert property (@(posedge clk) disable iff (!rstN)
    (!rateHit && rateCnt != CNT_MAX) |=> rateCnt == $past(rateCnt) + CNT_W'(1));

  // R5: the top value rolls over to zero
  a_r5_escape_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (!rateHit && rateCnt == CNT_MAX) |=> rateCnt == '0);

  // R11: release never goes below zero
  a_r11_release_floor: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RELEASE && envIn == '0) |=> envIn == '0);

  // R8: the step into 0xFF hands over to decay unless a gate edge intervenes
  a_r8_top_to_decay: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepUp && envIn == ENV_PRE_TOP && !gateSet && !gateClr) |=> phase == PH_DECAY);

  // R10: decay holds at the sustain level
  a_r10_sustain_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DECAY && envIn == susLevel && !gateSet && !gateClr) |=> $stable(envIn));

endmodule

// File: rtl/envgen_dp.sv
module envgen_dp
  import envgen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  env_strobe_t       stb,
  output logic [DATA_W-1:0] envOut
);

  logic [DATA_W-1:0] envReg;

  // Up-steps wrap modulo 2^DATA_W on purpose (R9).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             envReg <= '0;
    else if (stb.stepUp)   envReg <= envReg + DATA_W'(1);
    else if (stb.stepDown) envReg <= envReg - DATA_W'(1);
  end

  assign envOut = envReg;

  // R12: without a strobe the envelope holds
  a_r12_hold_without_step: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepUp && !stb.stepDown) |=> $stable(envReg));

  // R8: an up-step adds exactly one (wrapping, R9)
  a_r8_up_by_one: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepUp |=> envReg == DATA_W'($past(envReg) + DATA_W'(1)));

  // R11: a down-step removes exactly one
  a_r11_down_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepDown && !stb.stepUp) |=> envReg == DATA_W'($past(envReg) - DATA_W'(1)));

  // R3: the two strobes never fire together
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.stepUp && stb.stepDown));

endmodule

// File: rtl/envgen_top.sv
module envgen_top
  import envgen_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] envOut
);

  logic [DATA_W-1:0] atkDecReg, susRelReg;
  logic              gateSet, gateClr;
  env_strobe_t       stb;

  initial begin
    if (CNT_W < LIM_W) $error("CNT_W must hold the largest rate limit");
  end

  envgen_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .atkDecReg (atkDecReg),
    .susRelReg (susRelReg),
    .gateSet   (gateSet),
    .gateClr   (gateClr)
  );

  envgen_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .atkDecReg (atkDecReg),
    .susRelReg (susRelReg),
    .gateSet   (gateSet),
    .gateClr   (gateClr),
    .envIn     (envOut),
    .stb       (stb)
  );

  envgen_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .envOut (envOut)
  );

endmodule

// File: tb/envgen_top_tb_top.sv
`timescale 1ns/1ps
module envgen_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] envOut;

  always #2 clk = ~clk;   // 250 MHz

  envgen_top dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .envOut (envOut)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 0;
  string curReq  = "R1";

  // Reference model, built from the requirements.
  logic [7:0] expQ[$];
  logic [7:0] mEnv, mAd, mSr, mSus;
  int         mCnt, mPhase, mLim, mCode;   // phase: 0 attack, 1 decay, 2 release
  bit         mGate, mTick;

  function automatic int refLimit(input int code);
    case (code)
      0: return 9;      1: return 31;     2: return 62;     3: return 94;
      4: return 149;    5: return 219;    6: return 266;    7: return 312;
      8: return 391;    9: return 976;    10: return 1953;  11: return 3125;
      12: return 3906;  13: return 11719; 14: return 19531; default: return 31250;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEnv = 0; mAd = 0; mSr = 0; mCnt = 0; mPhase = 2; mGate = 0;
    end else begin
      mCode = (mPhase == 0) ? int'(mAd[7:4]) : (mPhase == 1) ? int'(mAd[3:0]) : int'(mSr[3:0]);
      mLim  = refLimit(mCode);
      mTick = (mCnt == mLim);
      mSus  = {mSr[7:4], mSr[7:4]};
      if (mTick) begin
        if (mPhase == 0) begin
          if (mEnv == 8'hFE) mPhase = 1;
          mEnv = mEnv + 8'd1;
        end else if (mPhase == 1) begin
          if (mEnv != mSus && mEnv != 0) mEnv = mEnv - 8'd1;
        end else if (mEnv != 0) begin
          mEnv = mEnv - 8'd1;
        end
      end
      mCnt = mTick ? 0 : (mCnt + 1) % 32768;
      if (wrEn) begin
        case (wrAddr)
          2'd0: mAd = wrData;
          2'd1: mSr = wrData;
          2'd2: begin
            if (wrData[0] && !mGate) mPhase = 0;
            if (!wrData[0] && mGate) mPhase = 2;
            mGate = wrData[0];
          end
          default: ;
        endcase
      end
    end
    expQ.push_back(mEnv);
  end

  // Monitor: scoreboard compare plus step-gap tracking.
  logic [7:0] prevEnv = 8'h00;
  int cyc = 0, lastChg = 0, lastGap = 0, chgCnt = 0;
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [7:0] e;
      e = expQ.pop_front();
      nChecks++;
      if (envOut !== e) begin
        nFails++;
        $display("FAIL %s/R12 envelope per cycle: actual %0h expected %0h at %0t", curReq, envOut, e, $time);
      end
    end
    cyc++;
    if (envOut != prevEnv) begin
      lastGap = cyc - lastChg;
      lastChg = cyc;
      chgCnt++;
      prevEnv = envOut;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitTick();
    int c0 = chgCnt;
    while (chgCnt == c0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 4);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    waitCycles(3);
    check(envOut == 8'h00, "R1 env in reset", envOut, 0);
    rstN = 1'b1;
    waitCycles(20);
    check(envOut == 8'h00, "R1 env after reset", envOut, 0);

    // R2/R7: program attack 0, decay 0, sustain 8, release 0, then gate on
    curReq = "R3";
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h01);
    waitTick();
    check(envOut == 8'h01, "R7 attack begins", envOut, 1);
    waitTick();
    check(lastGap == 10, "R3 R4 rate 0 period", lastGap, 10);

    curReq = "R4";
    wr(2'd0, 8'h10);
    waitTick(); waitTick();
    check(lastGap == 32, "R4 rate 1 period", lastGap, 32);
    wr(2'd0, 8'h40);
    waitTick(); waitTick();
    check(lastGap == 150, "R4 rate 4 period", lastGap, 150);

    // R6: shorter limit still ahead of the count matches in this pass
    curReq = "R6";
    wr(2'd0, 8'h00);
    waitTick();
    check(lastGap == 10, "R6 mid-period limit change", lastGap, 10);

    // R5: escape when the limit drops under the count
    curReq = "R5";
    wr(2'd0, 8'h40);
    waitTick(); waitTick();
    check(lastGap == 150, "R4 rate 4 before escape", lastGap, 150);
    waitCycles(50);
    wr(2'd0, 8'h00);
    waitTick();
    check(lastGap == 32778, "R5 escape gap", lastGap, 32778);
    waitTick();
    check(lastGap == 10, "R5 period after escape", lastGap, 10);

    // R8/R10: rise to the top, then decay to sustain 0x88
    curReq = "R10";
    waitCycles(5500);
    check(envOut == 8'h88, "R8 R10 decay settles at sustain", envOut, 8'h88);

    // R7/R2: repeated gate and unused address change nothing
    curReq = "R7";
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h00);
    waitCycles(200);
    check(envOut == 8'h88, "R7 R2 no effect from repeat gate or address 3", envOut, 8'h88);

    // R10: sustain raised above level: decay falls to zero and holds
    curReq = "R10";
    wr(2'd1, 8'hF0);
    waitCycles(2000);
    check(envOut == 8'h00, "R10 decay floor at zero", envOut, 0);

    // R11: release from the top down to zero
    curReq = "R11";
    wr(2'd1, 8'h80);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    waitCycles(3000);
    wr(2'd2, 8'h00);
    waitCycles(3000);
    check(envOut == 8'h00, "R11 release ends at zero", envOut, 0);

    // R9: attack re-entered at 0xFF wraps to 0x00
    curReq = "R9";
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    waitCycles(3000);
    check(envOut == 8'hFF, "R8 attack reaches top, decay holds at 0xFF", envOut, 8'hFF);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h01);
    waitTick();
    check(envOut == 8'h00, "R9 wrap to zero", envOut, 0);
    waitTick();
    check(envOut == 8'h01, "R9 keeps attacking after wrap", envOut, 1);
    check(lastGap == 10, "R9 attack period after wrap", lastGap, 10);

    waitCycles(5);
    finishRun();
  end

endmodule